// File: doc/BRIEF.md
# Monitoring Event Selection Filter

This block decides, once for every event the formatter has built, whether that event is copied into a read-only monitoring pipe that a bus host drains. Each event arrives as a one-cycle descriptor strobe. The descriptor carries four items:

- the event's error bitmap;
- a firmware-selected flag;
- the trigger type;
- the event length, counted in 32-bit words.

The filter combines this descriptor with static control bits, a per-code error mute mask, a trigger-type accept value, a global-error mute mask and the pipe's empty status. It then produces a verdict with three outputs: write the event, skip it as oversize, and raise global error code 4.

An event is a candidate if either of two parallel paths accepts it. One path accepts error-free events; the other accepts events the firmware flagged. When neither path accepts, the trigger type decides. Two further checks follow:

- A single-event mode lets a candidate through only while the pipe is empty, so the host always sees at most one event.
- Candidates longer than the pipe depth are skipped and reported.

Running totals of written and skipped events are kept and can be cleared synchronously.

Top module: `mon_evt_filter`

## Requirements
- R1: While `cfg_fmt_en` is 0, no verdict has `dec_wr`, `dec_skip` or `dec_gerr` set, whatever the descriptor.
- R2: With `cfg_err_en` set, an event is a candidate when `desc_err & ~err_mute` is zero; an unmasked error bit removes this path.
- R3: With `cfg_flt_en` set, an event whose `desc_fwsel` is 1 is a candidate.
- R4: When neither path of R2/R3 accepts, the event is a candidate if `cfg_tt_incl` is 0, or if `desc_ttype` equals `tt_accept`; otherwise it is dropped (all verdict bits 0).
- R5: A `tt_accept` value of 0 accepts every trigger type in the R4 check.
- R6: With `cfg_all` set, every candidate of normal length is written. With it clear, a candidate is written only when `pipe_empty` is 1; otherwise all verdict bits are 0.
- R7: A candidate with `desc_len` greater than 4096 gets `dec_skip`=1 and `dec_wr`=0; a length of exactly 4096 is written normally.
- R8: `dec_gerr` is 1 exactly when `dec_skip` is 1 and bit 4 of `gerr_mute` is 0.
- R9: The verdict appears on the clock edge that samples `desc_valid`; `dec_valid` pulses for one cycle then. The verdict holds until the next descriptor, regardless of input changes.
- R10: `wr_count` and `skip_count` each rise by one on the same edge as a verdict with `dec_wr` or `dec_skip` set. `cnt_clr` zeroes both on the next edge and takes priority over an increment.
- R11: After reset, all verdict outputs, `dec_valid` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| desc_valid | input | 1 | One-cycle strobe: descriptor inputs are valid |
| desc_err | input | 32 | Error bitmap of the event, one bit per code |
| desc_fwsel | input | 1 | Firmware-selected flag |
| desc_ttype | input | 8 | Trigger type of the event |
| desc_len | input | 16 | Event length in 32-bit words |
| cfg_fmt_en | input | 1 | Master enable for selection |
| cfg_err_en | input | 1 | Enables the error-free selection path |
| cfg_flt_en | input | 1 | Enables the firmware-flag selection path |
| cfg_tt_incl | input | 1 | Requires trigger-type match in the fallback |
| cfg_all | input | 1 | 1: write every candidate; 0: write only into an empty pipe |
| err_mute | input | 32 | Per-code error mask for the error path |
| gerr_mute | input | 32 | Global-error mask; bit 4 masks the oversize error |
| tt_accept | input | 8 | Accepted trigger type, 0 means any |
| pipe_empty | input | 1 | Monitoring pipe currently holds no data |
| dec_valid | output | 1 | Pulses one cycle when a new verdict is loaded |
| dec_wr | output | 1 | Verdict: copy the event into the pipe |
| dec_skip | output | 1 | Verdict: candidate skipped as oversize |
| dec_gerr | output | 1 | Verdict: global error code 4 raised |
| wr_count | output | 16 | Events written since reset or clear |
| skip_count | output | 16 | Events skipped since reset or clear |

## Verification
Several properties are checked on every cycle:
- the format-enable gate;
- the one-event gate when the pipe is busy;
- the ban on writing oversize events;
- the link between the skip and global-error outputs;
- the holding of the verdict between strobes;
- the increment and clear behaviour of both counters.

Only the bench scenarios can show the combined selection truth: which path admits an event under each mix of mute mask, firmware flag and trigger type. They also show the exact 4096/4097 length boundary and the accumulated counter totals over a run.

// File: rtl/mef_pkg.sv
package mef_pkg;
    parameter int ERR_W = 32;
    parameter int TT_W  = 8;
    parameter int LEN_W = 16;
    parameter int GERR_OVERSIZE_BIT = 4;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             fwsel;
        logic [TT_W-1:0]  ttype;
        logic [LEN_W-1:0] len;
    } evt_desc_t;

    typedef struct packed {
        logic fmt_en;
        logic err_en;
        logic flt_en;
        logic tt_incl;
        logic all_evt;
    } sel_ctrl_t;

    typedef struct packed {
        logic wr;
        logic skip;
        logic gerr;
    } verdict_t;

    function automatic logic tt_pass(input logic incl,
                                     input logic [TT_W-1:0] accept,
                                     input logic [TT_W-1:0] ttype);
        if (!incl)
            return 1'b1;
        return (accept == '0) || (accept == ttype);
    endfunction
endpackage

// File: rtl/mef_select.sv
module mef_select
    import mef_pkg::*;
(
    input  evt_desc_t        desc,
    input  sel_ctrl_t        ctrl,
    input  logic [ERR_W-1:0] err_mute,
    input  logic [TT_W-1:0]  tt_accept,
    output logic             candidate
);
    logic path_clean;
    logic path_flag;
    logic path_tt;

    always_comb begin
        path_clean = ctrl.err_en && ((desc.err & ~err_mute) == '0);
        path_flag  = ctrl.flt_en && desc.fwsel;
        path_tt    = tt_pass(ctrl.tt_incl, tt_accept, desc.ttype);
        candidate  = ctrl.fmt_en && (path_clean || path_flag || path_tt);
    end
endmodule

// File: rtl/mef_gate.sv
module mef_gate
    import mef_pkg::*;
#(
    parameter int MAX_WORDS = 4096
) (
    input  logic             candidate,
    input  logic [LEN_W-1:0] len,
    input  logic             all_evt,
    input  logic             pipe_empty,
    input  logic [31:0]      gerr_mute,
    output verdict_t         verdict
);
    logic oversize;

    always_comb begin
        oversize     = 32'(len) > 32'(MAX_WORDS);
        verdict.skip = candidate && oversize;
        verdict.wr   = candidate && !oversize && (all_evt || pipe_empty);
        verdict.gerr = verdict.skip && !gerr_mute[GERR_OVERSIZE_BIT];
    end
endmodule

// File: rtl/mef_counter.sv
module mef_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (count == $past(count) + 1'b1));
    a_r10_count_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));
    a_r10_count_idle: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/mon_evt_filter.sv
module mon_evt_filter
    import mef_pkg::*;
#(
    parameter int MAX_WORDS = 4096,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_clr,
    input  logic             desc_valid,
    input  logic [31:0]      desc_err,
    input  logic             desc_fwsel,
    input  logic [7:0]       desc_ttype,
    input  logic [15:0]      desc_len,
    input  logic             cfg_fmt_en,
    input  logic             cfg_err_en,
    input  logic             cfg_flt_en,
    input  logic             cfg_tt_incl,
    input  logic             cfg_all,
    input  logic [31:0]      err_mute,
    input  logic [31:0]      gerr_mute,
    input  logic [7:0]       tt_accept,
    input  logic             pipe_empty,
    output logic             dec_valid,
    output logic             dec_wr,
    output logic             dec_skip,
    output logic             dec_gerr,
    output logic [CNT_W-1:0] wr_count,
    output logic [CNT_W-1:0] skip_count
);
    evt_desc_t desc;
    sel_ctrl_t ctrl;
    logic      candidate;
    verdict_t  nxt;
    verdict_t  cur;
    logic      vld_q;

    always_comb begin
        desc.err     = desc_err;
        desc.fwsel   = desc_fwsel;
        desc.ttype   = desc_ttype;
        desc.len     = desc_len;
        ctrl.fmt_en  = cfg_fmt_en;
        ctrl.err_en  = cfg_err_en;
        ctrl.flt_en  = cfg_flt_en;
        ctrl.tt_incl = cfg_tt_incl;
        ctrl.all_evt = cfg_all;
    end

    mef_select u_select (
        .desc      (desc),
        .ctrl      (ctrl),
        .err_mute  (err_mute),
        .tt_accept (tt_accept),
        .candidate (candidate)
    );

    mef_gate #(.MAX_WORDS(MAX_WORDS)) u_gate (
        .candidate  (candidate),
        .len        (desc.len),
        .all_evt    (ctrl.all_evt),
        .pipe_empty (pipe_empty),
        .gerr_mute  (gerr_mute),
        .verdict    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= desc_valid;
            if (desc_valid)
                cur <= nxt;
        end
    end

    assign dec_valid = vld_q;
    assign dec_wr    = cur.wr;
    assign dec_skip  = cur.skip;
    assign dec_gerr  = cur.gerr;

    mef_counter #(.CNT_W(CNT_W)) u_wr_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (desc_valid && nxt.wr),
        .count (wr_count)
    );

    mef_counter #(.CNT_W(CNT_W)) u_skip_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (desc_valid && nxt.skip),
        .count (skip_count)
    );

    a_r1_fmt_off: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !cfg_fmt_en) |=> (!dec_wr && !dec_skip && !dec_gerr));
    a_r6_busy_pipe: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !cfg_all && !pipe_empty) |=> !dec_wr);
    a_r7_no_big_write: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && (32'(desc_len) > 32'(MAX_WORDS))) |=> !dec_wr);
    a_r8_gerr_needs_skip: assert property (@(posedge clk) disable iff (rst)
        dec_gerr |-> dec_skip);
    a_r8_gerr_muted: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && gerr_mute[GERR_OVERSIZE_BIT]) |=> !dec_gerr);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !desc_valid |=> $stable({dec_wr, dec_skip, dec_gerr}));
    a_r9_strobe: assert property (@(posedge clk) disable iff (rst)
        desc_valid |=> dec_valid);
endmodule

// File: tb/test_mon_evt_filter.sv
`timescale 1ns/1ps
module test_mon_evt_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_clr = 1'b0;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_err = '0;
    logic        desc_fwsel = 1'b0;
    logic [7:0]  desc_ttype = '0;
    logic [15:0] desc_len = 16'd10;
    logic        cfg_fmt_en = 1'b0, cfg_err_en = 1'b0, cfg_flt_en = 1'b0;
    logic        cfg_tt_incl = 1'b0, cfg_all = 1'b1;
    logic [31:0] err_mute = '0, gerr_mute = '0;
    logic [7:0]  tt_accept = '0;
    logic        pipe_empty = 1'b1;
    logic        dec_valid, dec_wr, dec_skip, dec_gerr;
    logic [15:0] wr_count, skip_count;

    int checks = 0;
    int errors = 0;
    int exp_wr_cnt = 0;
    int exp_skip_cnt = 0;
    bit done = 0;

    typedef struct { logic [2:0] v; string req; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    mon_evt_filter i_mon_evt_filter (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] err, input logic fw, input logic [7:0] tt,
                        input logic [15:0] len, input logic ew, input logic es,
                        input logic eg, input string req);
        exp_t e;
        @(negedge clk);
        desc_err = err; desc_fwsel = fw; desc_ttype = tt; desc_len = len;
        desc_valid = 1'b1;
        e.v = {ew, es, eg}; e.req = req;
        sb.push_back(e);
        if (ew) exp_wr_cnt++;
        if (es) exp_skip_cnt++;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    // monitor: pops an expected verdict whenever the design strobes a new one
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && dec_valid) begin
                if (sb.size() == 0) begin
                    check("R9 unexpected strobe", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req, {29'd0, dec_wr, dec_skip, dec_gerr}, {29'd0, e.v});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset verdict", {29'd0, dec_wr, dec_skip, dec_gerr}, 32'd0);
        check("R11 reset strobe", {31'd0, dec_valid}, 32'd0);
        check("R11 reset counts", {wr_count, skip_count}, 32'd0);

        // R1: everything passing but master enable off
        cfg_fmt_en = 0; cfg_flt_en = 1;
        send(32'h0, 1, 8'h3, 16'd5000, 0, 0, 0, "R1 fmt off");
        // R2: only the error path can pass (tt fallback blocked)
        cfg_fmt_en = 1; cfg_flt_en = 0; cfg_err_en = 1;
        cfg_tt_incl = 1; tt_accept = 8'h5;
        send(32'h0, 0, 8'h3, 16'd20, 1, 0, 0, "R2 clean event");
        send(32'h100, 0, 8'h3, 16'd20, 0, 0, 0, "R2 unmasked error");
        err_mute = 32'h100;
        send(32'h100, 0, 8'h3, 16'd20, 1, 0, 0, "R2 masked error");
        err_mute = 32'h0;
        // R3: firmware flag path
        cfg_err_en = 0; cfg_flt_en = 1;
        send(32'hFF, 1, 8'h3, 16'd20, 1, 0, 0, "R3 flagged");
        send(32'hFF, 0, 8'h3, 16'd20, 0, 0, 0, "R3 not flagged");
        // R4: trigger-type fallback
        cfg_flt_en = 0; cfg_tt_incl = 0;
        send(32'hFF, 0, 8'h9, 16'd20, 1, 0, 0, "R4 include off");
        cfg_tt_incl = 1;
        send(32'hFF, 0, 8'h5, 16'd20, 1, 0, 0, "R4 type match");
        send(32'hFF, 0, 8'h6, 16'd20, 0, 0, 0, "R4 type mismatch");
        // R5: accept zero
        tt_accept = 8'h0;
        send(32'hFF, 0, 8'h77, 16'd20, 1, 0, 0, "R5 accept any");
        // R6: single-event gate
        cfg_all = 0; pipe_empty = 0;
        send(32'h0, 0, 8'h1, 16'd20, 0, 0, 0, "R6 pipe busy");
        pipe_empty = 1;
        send(32'h0, 0, 8'h1, 16'd20, 1, 0, 0, "R6 pipe empty");
        cfg_all = 1; pipe_empty = 0;
        send(32'h0, 0, 8'h1, 16'd20, 1, 0, 0, "R6 all events");
        pipe_empty = 1;
        // R7 / R8: length boundary and global error
        send(32'h0, 0, 8'h1, 16'd4096, 1, 0, 0, "R7 exactly max");
        send(32'h0, 0, 8'h1, 16'd4097, 0, 1, 1, "R7 R8 oversize");
        gerr_mute = 32'h10;
        send(32'h0, 0, 8'h1, 16'd4097, 0, 1, 0, "R8 muted gerr");
        gerr_mute = 32'hFFFF_FFEF;
        send(32'h0, 0, 8'h1, 16'd9000, 0, 1, 1, "R8 other mute bits");
        gerr_mute = 0;
        cfg_fmt_en = 0;
        send(32'h0, 0, 8'h1, 16'd9000, 0, 0, 0, "R1 oversize disabled");
        cfg_fmt_en = 1;

        // R9: hold while inputs wander
        send(32'h0, 0, 8'h1, 16'd30, 1, 0, 0, "R9 load");
        cfg_fmt_en = 0; pipe_empty = 0; cfg_all = 0; desc_len = 16'd9999;
        repeat (3) @(negedge clk);
        check("R9 held wr", {29'd0, dec_wr, dec_skip, dec_gerr}, 32'd4);
        check("R9 strobe single", {31'd0, dec_valid}, 32'd0);
        cfg_fmt_en = 1; pipe_empty = 1; cfg_all = 1;

        // R10: counters
        @(negedge clk);
        check("R10 wr count", {16'd0, wr_count}, exp_wr_cnt);
        check("R10 skip count", {16'd0, skip_count}, exp_skip_cnt);
        cnt_clr = 1;
        @(negedge clk);
        cnt_clr = 0;
        check("R10 clear", {wr_count, skip_count}, 32'd0);
        // clear together with a writing descriptor: clear wins
        @(negedge clk);
        desc_err = 0; desc_len = 16'd8; desc_valid = 1; cnt_clr = 1;
        begin
            exp_t e; e.v = 3'b100; e.req = "R10 clr priority verdict"; sb.push_back(e);
        end
        @(negedge clk);
        desc_valid = 0; cnt_clr = 0;
        check("R10 clear priority", {16'd0, wr_count}, 32'd0);
        send(32'h0, 0, 8'h1, 16'd5000, 0, 1, 1, "R10 skip after clear");
        @(negedge clk);
        check("R10 count after clear", {wr_count, skip_count}, 32'h0000_0001);

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule